// File: doc/BRIEF.md
# Selectable-Operand Magnitude Comparator

This block decides whether an operand built from the `yb` inputs is greater than a second operand. It does so with an adder: it adds the `yb` operand to an addend that already holds the one's complement of the other operand, plus a carry-in, and reports the carry-out. A select input picks which buses build both operands. A mask input clears a replicated upper field of the `yb` operand. An extension input controls the two top bits of both operands.

Two results leave the block. One is the carry-out of the full 34-bit sum. The other is the carry-out of the low 17 bits of the same adder. The adder is split into carry-select blocks of alternating 5 and 4 bits, and the last block is 2 bits wide. Both results are registered once, so each becomes visible one clock after its inputs are sampled.

Top module: `mag_cmp_sel`

## Requirements
- R1: When `sel_i`=0, the `yb` operand bits [21:0] come from `yb_lo_i`. The addend bits [31:1] are `~xb_i[31:1]`, and addend bit 0 is forced to 0.
- R2: When `sel_i`=1, the `yb` operand bits [21:0] come from `xa_i`. The addend bits [31:1] are `ya_i[30:0]`, which arrives already inverted, and addend bit 0 is `~xb_i[0]`.
- R3: The `yb` operand bits [31:22] equal that operand's bits [9:0] when `mask_i`=1. They are all zero when `mask_i`=0.
- R4: In both modes, addend bits [33:32] are `~(xb_i[33:32] & {ext_i,ext_i})`, and `yb` operand bits [33:32] are `yb_hi_i | {~ext_i,~ext_i}`.
- R5: `gt_half_o` is the carry out of bit 16 of the sum `yb + addend + cin_i`, and `gt_o` is the carry out of bit 33 of that sum.
- R6: Both outputs are registered and show the result for the inputs sampled at the previous rising edge of `clk_i`. While `rst_ni` is low, both outputs are 0.
- R7: When `ext_i`=0, `gt_o` is 1 one cycle later, whatever the other inputs are.
- R8: `cin_i` is added at bit 0, so an equal pair of operands gives a full carry only when `cin_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Operand pairing select |
| mask_i | input | 1 | 1 keeps the replicated upper field of the `yb` operand |
| ext_i | input | 1 | Top-bit extension enable |
| cin_i | input | 1 | Adder carry-in |
| xa_i | input | 22 | Low `yb` operand bits when `sel_i`=1 |
| yb_lo_i | input | 22 | Low `yb` operand bits when `sel_i`=0 |
| yb_hi_i | input | 2 | Top `yb` operand bits before extension |
| xb_i | input | 34 | Compare operand (used inverted) |
| ya_i | input | 31 | Pre-inverted addend bits [31:1] when `sel_i`=1 |
| gt_o | output | 1 | Registered carry-out of the full 34-bit sum |
| gt_half_o | output | 1 | Registered carry-out of bit 16 |

## Verification
The bench targets several corner cases, each of which shows a specific failure. Equal operands with each carry-in value expose a design whose carry-in is dropped: it gives the wrong `gt_o` for one of the two. Patterns that place carries exactly at the bit-16 boundary expose a half result tapped one bit off, or a carry-select block boundary that selects the wrong carry. Toggling the mask while the low ten source bits are ones exposes a design that replicates the wrong bits or ignores the mask. Cases that differ only in `xb_i[0]` or in the top two bits expose a design that loses the bit-0 forcing rule or the extension rule, which would then flip `gt_o` on near-equal operands.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  // low bit index of carry-select block idx (alternating wa/wb widths)
  function automatic int blk_lo(int idx, int wa, int wb);
    return (idx / 2) * (wa + wb) + (idx % 2) * wa;
  endfunction

  function automatic int blk_w(int idx, int wa, int wb, int w);
    int sz;
    int rem;
    sz  = (idx % 2 != 0) ? wb : wa;
    rem = w - blk_lo(idx, wa, wb);
    return (sz < rem) ? sz : rem;
  endfunction

  function automatic int blk_cnt(int w, int wa, int wb);
    int n;
    n = 0;
    for (int i = 0; i < w; i++)
      if (blk_lo(i, wa, wb) < w) n = i + 1;
    return n;
  endfunction

  typedef struct packed {
    logic full;
    logic half;
  } cmp_res_t;

endpackage

// File: rtl/mag_cmp_operands.sv
module mag_cmp_operands #(
  parameter int W     = 34,
  parameter int LOW_W = 22,
  parameter int EXT_W = 2
) (
  input  logic             sel_i,
  input  logic             mask_i,
  input  logic             ext_i,
  input  logic [LOW_W-1:0] xa_i,
  input  logic [LOW_W-1:0] yb_lo_i,
  input  logic [EXT_W-1:0] yb_hi_i,
  input  logic [W-1:0]     xb_i,
  input  logic [W-EXT_W-2:0] ya_i,
  output logic [W-1:0]     yb_o,
  output logic [W-1:0]     nb_o
);
  localparam int MID   = W - EXT_W;
  localparam int REP_W = MID - LOW_W;

  logic [LOW_W-1:0] lo;

  always_comb begin
    lo   = sel_i ? xa_i : yb_lo_i;
    yb_o = {yb_hi_i | {EXT_W{~ext_i}}, lo[REP_W-1:0] & {REP_W{mask_i}}, lo};
    nb_o[0]         = sel_i & ~xb_i[0];
    nb_o[MID-1:1]   = sel_i ? ya_i : ~xb_i[MID-1:1];
    nb_o[W-1:MID]   = ~(xb_i[W-1:MID] & {EXT_W{ext_i}});
  end

endmodule

// File: rtl/csel_block.sv
module csel_block #(
  parameter int BW = 4
) (
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  input  logic          cin_i,
  output logic [BW-1:0] co_o
);
  logic [BW-1:0] r0, r1;
  logic c0, c1;

  // both carry-in hypotheses, selected late by the real carry
  always_comb begin
    c0 = 1'b0;
    c1 = 1'b1;
    for (int j = 0; j < BW; j++) begin
      c0 = (a_i[j] & b_i[j]) | ((a_i[j] ^ b_i[j]) & c0);
      c1 = (a_i[j] & b_i[j]) | ((a_i[j] ^ b_i[j]) & c1);
      r0[j] = c0;
      r1[j] = c1;
    end
  end

  assign co_o = cin_i ? r1 : r0;

endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int W     = 34,
  parameter int BLK_A = 5,
  parameter int BLK_B = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] cy_o
);
  import mag_cmp_pkg::*;

  localparam int NB = blk_cnt(W, BLK_A, BLK_B);

  logic [NB-1:0] bc;
  assign bc[0] = cin_i;

  for (genvar i = 0; i < NB; i++) begin : g_blk
    localparam int LO = blk_lo(i, BLK_A, BLK_B);
    localparam int BW = blk_w(i, BLK_A, BLK_B, W);
    csel_block #(.BW(BW)) u_blk (
      .a_i  (a_i[LO+BW-1:LO]),
      .b_i  (b_i[LO+BW-1:LO]),
      .cin_i(bc[i]),
      .co_o (cy_o[LO+BW-1:LO])
    );
    if (i < NB - 1) begin : g_link
      assign bc[i+1] = cy_o[LO+BW-1];
    end
  end

endmodule

// File: rtl/mag_cmp_sel.sv
module mag_cmp_sel #(
  parameter int W      = 34,
  parameter int LOW_W  = 22,
  parameter int EXT_W  = 2,
  parameter int HALF_W = 17,
  parameter int BLK_A  = 5,
  parameter int BLK_B  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               mask_i,
  input  logic               ext_i,
  input  logic               cin_i,
  input  logic [LOW_W-1:0]   xa_i,
  input  logic [LOW_W-1:0]   yb_lo_i,
  input  logic [EXT_W-1:0]   yb_hi_i,
  input  logic [W-1:0]       xb_i,
  input  logic [W-EXT_W-2:0] ya_i,
  output logic               gt_o,
  output logic               gt_half_o
);
  import mag_cmp_pkg::*;

  logic [W-1:0] yb, nb, cy;
  cmp_res_t res_q;

  mag_cmp_operands #(.W(W), .LOW_W(LOW_W), .EXT_W(EXT_W)) u_ops (
    .sel_i  (sel_i),
    .mask_i (mask_i),
    .ext_i  (ext_i),
    .xa_i   (xa_i),
    .yb_lo_i(yb_lo_i),
    .yb_hi_i(yb_hi_i),
    .xb_i   (xb_i),
    .ya_i   (ya_i),
    .yb_o   (yb),
    .nb_o   (nb)
  );

  csel_adder #(.W(W), .BLK_A(BLK_A), .BLK_B(BLK_B)) u_add (
    .a_i  (yb),
    .b_i  (nb),
    .cin_i(cin_i),
    .cy_o (cy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= '{full: cy[W-1], half: cy[HALF_W-1]};
  end

  assign gt_o      = res_q.full;
  assign gt_half_o = res_q.half;

  // reference carries from a plain wide add, for the checks below
  logic [W:0]   ref_sum;
  logic [W-1:0] ref_x, ref_cy;
  assign ref_sum = {1'b0, yb} + {1'b0, nb} + {{W{1'b0}}, cin_i};
  assign ref_x   = yb ^ nb ^ ref_sum[W-1:0];
  assign ref_cy  = {ref_sum[W], ref_x[W-1:1]};

  AST_CARRY_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cy == ref_cy) && (ref_x[0] == cin_i)); // R5
  AST_FULL_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> gt_o == $past(ref_sum[W])); // R6
  AST_HALF_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> gt_half_o == $past(ref_cy[HALF_W-1])); // R5
  AST_EXT_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_i |=> gt_o); // R7

endmodule

// File: tb/mag_cmp_sel_bench.sv
`timescale 1ns/1ps
module mag_cmp_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel, mask, ext, cin;
  logic [21:0] xa, ybl;
  logic [1:0]  ybh;
  logic [33:0] xb;
  logic [30:0] ya;
  logic        gt, gt_half;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  mag_cmp_sel u_mag_cmp_sel (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .mask_i(mask), .ext_i(ext),
    .cin_i(cin), .xa_i(xa), .yb_lo_i(ybl), .yb_hi_i(ybh), .xb_i(xb),
    .ya_i(ya), .gt_o(gt), .gt_half_o(gt_half)
  );

  function automatic logic [1:0] model(logic s, logic m, logic e, logic c,
      logic [21:0] a, logic [21:0] yl, logic [1:0] yh, logic [33:0] x, logic [30:0] y1);
    logic [33:0] y, b;
    logic [34:0] sum;
    logic [17:0] h;
    for (int k = 0; k < 22; k++) y[k] = s ? a[k] : yl[k];
    for (int k = 22; k < 32; k++) y[k] = m & y[k-22];
    for (int k = 32; k < 34; k++) y[k] = yh[k-32] | ~e;
    b[0] = s ? ~x[0] : 1'b0;
    for (int k = 1; k < 32; k++) b[k] = s ? y1[k-1] : ~x[k];
    for (int k = 32; k < 34; k++) b[k] = ~(x[k] & e);
    sum = {1'b0, y} + {1'b0, b} + {34'd0, c};
    h   = {1'b0, y[16:0]} + {1'b0, b[16:0]} + {17'd0, c};
    return {sum[34], h[17]};
  endfunction

  task automatic drive(logic s, logic m, logic e, logic c, logic [21:0] a,
      logic [21:0] yl, logic [1:0] yh, logic [33:0] x, logic [30:0] y1, string tag);
    @(negedge clk);
    sel = s; mask = m; ext = e; cin = c; xa = a; ybl = yl; ybh = yh; xb = x; ya = y1;
    q.push_back('{exp: model(s, m, e, c, a, yl, yh, x, y1), tag: tag});
  endtask

  task automatic check(logic [1:0] act, logic [1:0] exp, string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual full/half=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: results appear one edge after the driving negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({gt, gt_half}, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    sel = 1'b1; mask = 1'b1; ext = 1'b0; cin = 1'b1;
    xa = '1; ybl = '1; ybh = '1; xb = '0; ya = '1;
    repeat (3) @(negedge clk);
    check({gt, gt_half}, 2'b00, "R6 reset");
    rst_n = 1'b1;

    // R1: sel=0, bit 0 of addend forced 0
    drive(0, 1, 1, 0, 22'h0, 22'd100, 2'b00, 34'd99, 31'h0, "R1 gt");
    drive(0, 1, 1, 0, 22'h0, 22'd99, 2'b00, 34'd100, 31'h0, "R1 lt");
    drive(0, 1, 1, 0, 22'h0, 22'd6, 2'b00, 34'd6, 31'h0, "R1 eq even");
    drive(0, 1, 1, 0, 22'h0, 22'd6, 2'b00, 34'd7, 31'h0, "R1 xb0 ignored");
    // R2: sel=1 routing and bit 0 from xb
    drive(1, 1, 1, 0, 22'h3ff, 22'h0, 2'b11, 34'h0, 31'h7fffffff, "R2 ya ones");
    drive(1, 1, 1, 0, 22'h1, 22'h0, 2'b00, 34'h1, 31'h0, "R2 xb0 set");
    drive(1, 1, 1, 0, 22'h1, 22'h0, 2'b00, 34'h0, 31'h0, "R2 xb0 clr");
    drive(1, 0, 1, 1, 22'h12345, 22'h3fffff, 2'b01, 34'h3, 31'h5a5a5a5a, "R2 mix");
    // R3: mask on replicated field
    drive(0, 1, 1, 0, 22'h0, 22'h3ff, 2'b00, 34'h3_ffff_ffff, 31'h0, "R3 mask on");
    drive(0, 0, 1, 0, 22'h0, 22'h3ff, 2'b00, 34'h0_ffc0_0000, 31'h0, "R3 mask off");
    drive(1, 1, 1, 0, 22'h3ff, 22'h0, 2'b00, 34'h0, 31'h7fe00000, "R3 sel1 on");
    drive(1, 0, 1, 0, 22'h3ff, 22'h0, 2'b00, 34'h0, 31'h7fe00000, "R3 sel1 off");
    // R4: extension of top bits
    drive(0, 1, 1, 0, 22'h0, 22'h0, 2'b10, 34'h1_0000_0000, 31'h0, "R4 hi gt");
    drive(0, 1, 1, 0, 22'h0, 22'h0, 2'b01, 34'h2_0000_0000, 31'h0, "R4 hi lt");
    // R5: carries at the bit-16 boundary
    drive(0, 1, 1, 0, 22'h1ffff, 22'h1ffff, 2'b00, 34'h3_fffe_0001, 31'h0, "R5 half edge");
    drive(1, 1, 1, 1, 22'h0ffff, 22'h0, 2'b00, 34'h0, 31'h00007fff, "R5 tap15");
    drive(1, 1, 1, 0, 22'h10000, 22'h0, 2'b00, 34'h0, 31'h00008000, "R5 tap16");
    // R7: ext=0 forces full carry
    for (int i = 0; i < 20; i++)
      drive(i[0], i[1], 0, i[2], 22'($urandom()), 22'($urandom()), 2'($urandom()),
            34'({$urandom(), $urandom()}), 31'($urandom()), "R7 ext off");
    // R8: carry-in on equal operands
    drive(0, 1, 1, 1, 22'h0, 22'd6, 2'b00, 34'd6, 31'h0, "R8 eq cin1");
    drive(1, 1, 1, 1, 22'h0, 22'h0, 2'b00, 34'h1, 31'h7fffffff, "R8 sel1 cin1");
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic s;
      s = 1'($urandom());
      drive(s, 1'($urandom()), 1'($urandom()), 1'($urandom()), 22'($urandom()),
            22'($urandom()), 2'($urandom()), 34'({$urandom(), $urandom()}),
            31'($urandom()), s ? "R2 random" : "R1 random");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule